// File: doc/BRIEF.md
# Deferred-Normalization Mantissa Multiplier Chain

This block multiplies a run of floating-point operands, each given as an unsigned fraction mantissa and a signed exponent, into one running product. The product is not renormalized between steps. It is held with extra low guard bits, so the drift of up to one bit per multiply stays inside the register. The leading-one search, the left shift and the exponent correction happen once, when the controller issues a separate normalize command at the end of the chain. The controller uses it by loading the first operand, issuing any number of multiply commands with the later operands, and then issuing normalize before storing the one-cycle result.

The controller is a three-state machine:
- `S_EMPTY`: no chain is held.
- `S_CHAIN`: a running product is held.
- `S_DONE`: the cycle that presents a freshly normalized result.

Transitions:
- Load: `S_EMPTY`, `S_CHAIN` or `S_DONE` go to `S_CHAIN`.
- Multiply: `S_CHAIN` goes to `S_CHAIN`.
- Normalize: `S_CHAIN` goes to `S_DONE`.
- Expire: `S_DONE` goes to `S_EMPTY`, unless a load arrives in that cycle.
- Idle: `S_EMPTY` stays in `S_EMPTY` and `S_CHAIN` stays in `S_CHAIN`.

Top module: `defer_norm_mul`

## Requirements
- R1: After reset, `res_valid_o` is 0, `res_mant_o` and `res_exp_o` are 0, and no chain is held (`S_EMPTY`).
- R2: A load places the operand mantissa in the running product, followed by 4 zero guard bits (28 bits total), and takes the operand exponent. A load wins over multiply and normalize in the same cycle and gives no valid pulse. A load is accepted in any state.
- R3: A multiply while a chain is held replaces the running product with the top 28 bits of the 52-bit product (running product × 24-bit operand mantissa). It adds the operand exponent modulo 2^10. The intermediate result is not normalized.
- R4: A multiply or normalize issued while no chain is held (`S_EMPTY` or `S_DONE`) is ignored: no valid pulse, and the result fields keep their values.
- R5: Normalize on a nonzero product shifts it left until bit 27 is 1. The result mantissa is bits 27..4 of the shifted value, and the result exponent is the held exponent minus the shift count, modulo 2^10.
- R6: `res_valid_o` is 1 for exactly the one cycle that follows an accepted normalize. The result fields hold their values until the next accepted normalize.
- R7: A zero running product normalizes to mantissa 0 and exponent 0, whatever the held exponent.
- R8: After a load and up to 4 multiplies, all with normalized operands (bit 23 set), the normalized result is within a relative error of 2^-19 of a reference that normalizes after every step.
- R9: While a chain is held, multiply wins over normalize in the same cycle. An accepted normalize consumes the chain, so a new load is needed before the next multiply or normalize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a chain with the operand |
| mul_i | input | 1 | Multiply the running product by the operand |
| norm_i | input | 1 | Normalize the running product and end the chain |
| op_mant_i | input | 24 | Operand mantissa, unsigned fraction |
| op_exp_i | input | 10 | Operand exponent, two's complement |
| res_mant_o | output | 24 | Normalized result mantissa |
| res_exp_o | output | 10 | Normalized result exponent, two's complement |
| res_valid_o | output | 1 | One-cycle result strobe |

## Verification
A wrong running product or exponent stays hidden until the next normalize. At that point it shows as a wrong mantissa or exponent in the single valid cycle, so each chain ends in a check. A wrong state shows sooner, as a missing, doubled or spurious valid pulse in the cycle after a command. A reference model updated on every clock compares valid, mantissa and exponent on every cycle. A second model, which normalizes after each step, bounds the precision of the deferred chains.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_CHAIN = 2'd1,
        S_DONE  = 2'd2
    } dnm_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_MUL  = 2'd2,
        OP_NORM = 2'd3
    } dnm_op_e;
endpackage

// File: rtl/dnm_mant_mul.sv
module dnm_mant_mul #(
    parameter int MANT_W  = 24,
    parameter int GUARD_W = 4,
    parameter int EXP_W   = 10
) (
    input  logic [MANT_W+GUARD_W-1:0] run_mant,
    input  logic [EXP_W-1:0]          run_exp,
    input  logic [MANT_W-1:0]         op_mant,
    input  logic [EXP_W-1:0]          op_exp,
    output logic [MANT_W+GUARD_W-1:0] nxt_mant,
    output logic [EXP_W-1:0]          nxt_exp
);
    localparam int RUN_W  = MANT_W + GUARD_W;
    localparam int PROD_W = RUN_W + MANT_W;

    logic [PROD_W-1:0] full_prod;

    // Keep the upper part of the product; no renormalization here.
    assign full_prod = PROD_W'(run_mant) * PROD_W'(op_mant);
    assign nxt_mant  = full_prod[PROD_W-1 -: RUN_W];
    assign nxt_exp   = run_exp + op_exp;
endmodule

// File: rtl/dnm_lead_zero.sv
module dnm_lead_zero #(
    parameter int W = 28,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] zeros,
    output logic             is_zero
);
    logic [W-1:0] hit;

    // Bit i is the leading one when it is set and everything above it is clear.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_hit
            if (gi == W - 1) begin : g_top
                assign hit[gi] = vec[gi];
            end else begin : g_low
                assign hit[gi] = vec[gi] & ~(|vec[W-1:gi+1]);
            end
        end
    endgenerate

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            if (hit[i]) zeros = CNT_W'(W - 1 - i);
        end
    end

    assign is_zero = ~(|vec);
endmodule

// File: rtl/dnm_normalize.sv
module dnm_normalize #(
    parameter int MANT_W  = 24,
    parameter int GUARD_W = 4,
    parameter int EXP_W   = 10
) (
    input  logic [MANT_W+GUARD_W-1:0] run_mant,
    input  logic [EXP_W-1:0]          run_exp,
    output logic [MANT_W-1:0]         norm_mant,
    output logic [EXP_W-1:0]          norm_exp
);
    localparam int RUN_W = MANT_W + GUARD_W;
    localparam int CNT_W = $clog2(RUN_W + 1);

    logic [CNT_W-1:0] lz;
    logic             zero_in;
    logic [RUN_W-1:0] shifted;

    dnm_lead_zero #(.W(RUN_W)) u_lz (
        .vec     (run_mant),
        .zeros   (lz),
        .is_zero (zero_in)
    );

    assign shifted = run_mant << lz;

    always_comb begin
        if (zero_in) begin
            norm_mant = '0;
            norm_exp  = '0;
        end else begin
            norm_mant = shifted[RUN_W-1 -: MANT_W];
            norm_exp  = run_exp - EXP_W'(lz);
        end
    end
endmodule

// File: rtl/defer_norm_mul.sv
module defer_norm_mul #(
    parameter int MANT_W  = 24,
    parameter int GUARD_W = 4,
    parameter int EXP_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              mul_i,
    input  logic              norm_i,
    input  logic [MANT_W-1:0] op_mant_i,
    input  logic [EXP_W-1:0]  op_exp_i,
    output logic [MANT_W-1:0] res_mant_o,
    output logic [EXP_W-1:0]  res_exp_o,
    output logic              res_valid_o
);
    import dnm_pkg::*;

    localparam int RUN_W = MANT_W + GUARD_W;

    dnm_state_e        state, state_nxt;
    dnm_op_e           op;
    logic [RUN_W-1:0]  run_mant;
    logic [EXP_W-1:0]  run_exp;
    logic [RUN_W-1:0]  mul_mant;
    logic [EXP_W-1:0]  mul_exp;
    logic [MANT_W-1:0] nrm_mant;
    logic [EXP_W-1:0]  nrm_exp;

    dnm_mant_mul #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_mul (
        .run_mant (run_mant),
        .run_exp  (run_exp),
        .op_mant  (op_mant_i),
        .op_exp   (op_exp_i),
        .nxt_mant (mul_mant),
        .nxt_exp  (mul_exp)
    );

    dnm_normalize #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_norm (
        .run_mant  (run_mant),
        .run_exp   (run_exp),
        .norm_mant (nrm_mant),
        .norm_exp  (nrm_exp)
    );

    // Command decode: load first, then multiply, then normalize (chain only).
    always_comb begin
        op = OP_NONE;
        if (load_i)                                 op = OP_LOAD;
        else if (state == S_CHAIN && mul_i)         op = OP_MUL;
        else if (state == S_CHAIN && norm_i)        op = OP_NORM;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_EMPTY: if (op == OP_LOAD) state_nxt = S_CHAIN;
            S_CHAIN: if (op == OP_NORM) state_nxt = S_DONE;
            S_DONE:  state_nxt = (op == OP_LOAD) ? S_CHAIN : S_EMPTY;
            default: state_nxt = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_mant   <= '0;
            run_exp    <= '0;
            res_mant_o <= '0;
            res_exp_o  <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    run_mant <= {op_mant_i, {GUARD_W{1'b0}}};
                    run_exp  <= op_exp_i;
                end
                OP_MUL: begin
                    run_mant <= mul_mant;
                    run_exp  <= mul_exp;
                end
                OP_NORM: begin
                    res_mant_o <= nrm_mant;
                    res_exp_o  <= nrm_exp;
                end
                default: ;
            endcase
        end
    end

    always_comb res_valid_o = (state == S_DONE);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    a_r6_valid_after_norm: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(op == OP_NORM));
    a_r5_top_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_mant_o != '0) |-> res_mant_o[MANT_W-1]);
    a_r7_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_mant_o == '0) |-> (res_exp_o == '0));
    a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY && !load_i) |=> (state == S_EMPTY));
    a_r2_load_enters_chain: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state == S_CHAIN && !res_valid_o));
    a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(res_mant_o) && $stable(res_exp_o)));
endmodule

// File: tb/test_defer_norm_mul.sv
module test_defer_norm_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, mul_i = 1'b0, norm_i = 1'b0;
    logic [23:0] op_mant_i = '0;
    logic [9:0]  op_exp_i = '0;
    logic [23:0] res_mant_o;
    logic [9:0]  res_exp_o;
    logic        res_valid_o;

    int checks = 0;
    int failures = 0;

    // Deferred model state
    longint unsigned m_acc = 0;
    logic [9:0]      m_exp = '0;
    bit              m_have = 0;
    bit              e_valid = 0;
    logic [23:0]     e_mant = '0;
    logic [9:0]      e_exp = '0;
    // Per-step normalized reference
    longint unsigned r_mant = 0;
    logic [9:0]      r_exp = '0;
    bit              r_ok = 0;
    bit              tol_due = 0;

    defer_norm_mul i_defer_norm_mul (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mul_i(mul_i), .norm_i(norm_i),
        .op_mant_i(op_mant_i), .op_exp_i(op_exp_i),
        .res_mant_o(res_mant_o), .res_exp_o(res_exp_o), .res_valid_o(res_valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input bit ld, input bit mu, input bit nm,
                         input logic [23:0] m, input logic [9:0] e);
        longint unsigned p;
        int sh;
        e_valid = 0;
        tol_due = 0;
        if (ld) begin
            m_acc = longint'(m) << 4; m_exp = e; m_have = 1;
            r_mant = m; r_exp = e; r_ok = m[23];
        end else if (m_have && mu) begin
            m_acc = (m_acc * m) >> 24; m_exp = m_exp + e;
            p = r_mant * m;
            r_exp = r_exp + e;
            if (p[47] == 1'b0) begin p = p << 1; r_exp = r_exp - 10'd1; end
            r_mant = p >> 24;
            r_ok = r_ok & m[23];
        end else if (m_have && nm) begin
            if (m_acc == 0) begin
                e_mant = '0; e_exp = '0;
            end else begin
                sh = 0;
                while (((m_acc << sh) & 64'h800_0000) == 0) sh++;
                e_mant = 24'((m_acc << sh) >> 4);
                e_exp = m_exp - 10'(sh);
                tol_due = r_ok;
            end
            e_valid = 1; m_have = 0;
        end
    endtask

    task automatic step(input string tag, input bit ld, input bit mu, input bit nm,
                        input logic [23:0] m, input logic [9:0] e);
        real ratio;
        load_i = ld; mul_i = mu; norm_i = nm; op_mant_i = m; op_exp_i = e;
        model(ld, mu, nm, m, e);
        @(posedge clk);
        @(negedge clk);
        check(res_valid_o == e_valid, {tag, " valid"}, longint'(res_valid_o), longint'(e_valid));
        check(res_mant_o == e_mant, {tag, " mant"}, longint'(res_mant_o), longint'(e_mant));
        check(res_exp_o == e_exp, {tag, " exp"}, longint'(res_exp_o), longint'(e_exp));
        if (tol_due) begin
            ratio = (real'(res_mant_o) / real'(r_mant)) *
                    (2.0 ** real'($signed(10'(res_exp_o - r_exp))));
            check((ratio - 1.0 < 1.0/524288.0) && (1.0 - ratio < 1.0/524288.0),
                  "R8 precision vs per-step reference", longint'(res_mant_o), longint'(r_mant));
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 24'h0, 10'h0);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(res_valid_o == 0, "R1 valid", longint'(res_valid_o), 0);
        check(res_mant_o == 0 && res_exp_o == 0, "R1 result", longint'(res_mant_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: commands with no chain held are ignored
        step("R4 mul empty", 0, 1, 0, 24'h900000, 10'h3);
        step("R4 norm empty", 0, 0, 1, 24'h900000, 10'h3);

        // R2/R3/R5: simple chain, and no-shift normalize
        step("R2 load", 1, 0, 0, 24'hC00000, 10'd1);
        for (int i = 0; i < 4; i++) step("R3 mul", 0, 1, 0, 24'h800000, 10'd0);
        step("R5 norm", 0, 0, 1, 0, 0);
        idle("R6 single pulse");
        step("R2 load full", 1, 0, 0, 24'hFFFFFF, 10'd7);
        step("R5 norm noshift", 0, 0, 1, 0, 0);

        // R4/R9: commands in the done cycle are ignored, results hold
        step("R2 load", 1, 0, 0, 24'hA00000, 10'd2);
        step("R5 norm", 0, 0, 1, 0, 0);
        step("R9 mul after norm", 0, 1, 0, 24'h800000, 10'd1);
        step("R9 norm after norm", 0, 0, 1, 0, 0);
        idle("R6 result holds");

        // R2 priority: load wins over mul and norm
        step("R2 load", 1, 0, 0, 24'h812345, 10'd4);
        step("R2 load priority", 1, 1, 1, 24'hF0F0F0, 10'h3FE);
        step("R5 norm loaded", 0, 0, 1, 0, 0);

        // R9 priority: multiply over normalize
        step("R2 load", 1, 0, 0, 24'h9E3779, 10'd0);
        step("R9 mul wins", 0, 1, 1, 24'hB504F3, 10'd1);
        step("R5 norm", 0, 0, 1, 0, 0);

        // R7: zero product, nonzero held exponent
        step("R2 load zero", 1, 0, 0, 24'h0, 10'd9);
        step("R3 mul zero", 0, 1, 0, 24'hC00000, 10'd3);
        step("R7 norm zero", 0, 0, 1, 0, 0);

        // R3: exponent wraps modulo 2^10
        step("R2 load", 1, 0, 0, 24'h800000, 10'h20C);
        step("R3 mul wrap", 0, 1, 0, 24'h800000, 10'h3EC);
        step("R3 norm wrap", 0, 0, 1, 0, 0);

        // R8: four-deep chain of awkward normalized operands
        step("R2 load", 1, 0, 0, 24'h800001, 10'd0);
        step("R8 mul", 0, 1, 0, 24'hFFFFFF, 10'd1);
        step("R8 mul", 0, 1, 0, 24'hAAAAAA, 10'h3FF);
        step("R8 mul", 0, 1, 0, 24'h800000, 10'd2);
        step("R8 mul", 0, 1, 0, 24'h9E3779, 10'd0);
        step("R8 norm", 0, 0, 1, 0, 0);

        // R3/R5/R8: random chains of depth 1..4
        for (int c = 0; c < 60; c++) begin
            int depth;
            depth = 1 + ($urandom % 4);
            step("R2 load rnd", 1, 0, 0, 24'h800000 | 24'($urandom), 10'($urandom % 16));
            for (int k = 0; k < depth; k++)
                step("R3 mul rnd", 0, 1, 0, 24'h800000 | 24'($urandom), 10'($urandom % 16));
            step("R5 norm rnd", 0, 0, 1, 0, 0);
        end
        idle("R6 end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule